// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block turns local-bus addresses into PCI bus addresses through three programmable windows. Each window owns a base register (base address, size, enable, prefetch hint) and a map register (target address bits, cycle kind, low-bit control). A lookup is presented with `req_valid` and `req_addr`. One clock later the block reports the translated bus address, the cycle type (memory, I/O or configuration), a prefetchable flag, and whether any window matched.

Windows may overlap. They are examined from index 0 upward, and the lowest-numbered enabled window that covers the address supplies the translation. Software relies on this ordering. It can widen window 0 so that it hides window 1, point window 1 at configuration space, and then shrink window 0 again afterwards. Window 2 is dedicated to I/O: its size is fixed at 16 MB and it maps its base to bus address zero.

Registers are written through a simple write port. `wr_win` selects the window, and `wr_sel` selects the base register (0) or the map register (1).

Top module: `pci_win_xlat`

## Requirements
- R1: A window whose enable bit is clear never matches. When no window matches, a lookup reports rsp_hit=0, rsp_type=0 (none), rsp_win=0, rsp_addr=0 and rsp_prefetch=0. After reset every window is disabled.
- R2: When several enabled windows cover an address, the lowest index wins, and rsp_win reports that index.
- R3: The base register is laid out as follows. Bits [31:24] hold base address bits A31:A24. Bit [3] is the prefetch hint. Bit [0] is the enable. Bits [2:1] select the size: 0 = 16 MB, 1 = 256 MB, 2 = 512 MB, 3 = 16 MB. Base bits that fall inside the window size are ignored, so the window is always aligned to its size.
- R4: The map register is laid out as follows. Bits [15:8] hold target address bits A31:A24, bits [3:1] hold the cycle kind, and bit [0] is the low-bit pass control. For windows 0 and 1, any kind other than 3'b101 gives a memory cycle (rsp_type=1). The translated address is then the target bits above the window size combined with the address offset inside the window.
- R5: On window 0 or 1, kind 3'b101 gives a configuration cycle (rsp_type=3), translated the same way as a memory cycle. Address bits [1:0] are forced to 00 when map bit 0 is clear and pass through from req_addr when it is set. rsp_prefetch is 0 for configuration cycles.
- R6: Window 2 always spans 16 MB, whatever its size field holds, and always yields I/O cycles (rsp_type=2). Its base maps to bus address 0, so the result is the offset inside the window. Writes to its map register and its prefetch bit have no effect on results.
- R7: For a memory hit, rsp_prefetch equals the prefetch bit of the winning window's base register.
- R8: rsp_valid is high exactly one cycle after req_valid was high, and the result reflects the address presented in that earlier cycle.
- R9: A register write changes lookups presented from the next cycle onward. A lookup presented in the same cycle as the write uses the old register value.
- R10: During and right after reset, rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 2 | Window index for the write (3 is ignored) |
| wr_sel | input | 1 | 0 = base register, 1 = map register |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Local-bus address to translate |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 2 | Index of the winning window |
| rsp_type | output | 2 | 0 none, 1 memory, 2 I/O, 3 configuration |
| rsp_addr | output | 32 | Translated PCI bus address |
| rsp_prefetch | output | 1 | Winning memory window is prefetchable |

## Verification
The bench first places windows on the usual 256 MB memory and 16 MB I/O layout and sweeps addresses at window edges and just outside them. If the window-2 size field were honoured, an address one byte past 16 MB would hit instead of missing.

Widening window 0 to 512 MB must hide window 1. A decoder that searched from the top, or that merged all hits, would report window 1 or a mixed address.

Configuration lookups are run with the low-bit control both clear and set, so that a swapped control shows up as wrong bits [1:0]. A window-1 region placed over window 2 checks priority in the upper pair.

Finally, a write and a lookup are issued in the same cycle. A design that forwarded the new value would report a hit where the old state gives a miss.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int ADDR_W   = 32;
    localparam int NUM_WIN  = 3;
    localparam int IO_WIN   = 2;
    localparam int WIN_W    = $clog2(NUM_WIN + 1);
    localparam int PAGE_LSB = 24;
    localparam int HI_W     = ADDR_W - PAGE_LSB;

    localparam logic [2:0] KIND_CFG = 3'b101;

    typedef enum logic [1:0] {
        CYC_NONE = 2'd0,
        CYC_MEM  = 2'd1,
        CYC_IO   = 2'd2,
        CYC_CFG  = 2'd3
    } cyc_e;

    typedef enum logic [1:0] {
        SZ_16M  = 2'd0,
        SZ_256M = 2'd1,
        SZ_512M = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef struct packed {
        logic [HI_W-1:0] base_hi;
        logic            pref;
        size_e           size;
        logic            en;
    } base_t;

    typedef struct packed {
        logic [HI_W-1:0] tgt_hi;
        logic [2:0]      kind;
        logic            low_en;
    } map_t;

    typedef struct packed {
        logic              hit;
        cyc_e              cyc;
        logic              pref;
        logic [ADDR_W-1:0] addr;
    } xlat_t;

    // Offset mask: the address bits that lie inside a window of the given size.
    function automatic logic [ADDR_W-1:0] offset_mask(input size_e sz);
        logic [ADDR_W-1:0] m;
        case (sz)
            SZ_256M: m = {{(ADDR_W-28){1'b0}}, {28{1'b1}}};
            SZ_512M: m = {{(ADDR_W-29){1'b0}}, {29{1'b1}}};
            default: m = {{(ADDR_W-PAGE_LSB){1'b0}}, {PAGE_LSB{1'b1}}};
        endcase
        return m;
    endfunction
endpackage

// File: rtl/xlat_regs.sv
module xlat_regs
    import xlat_pkg::*;
#(
    parameter int N_WIN = NUM_WIN,
    parameter int IO_IDX = IO_WIN
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [WIN_W-1:0]        wr_win,
    input  logic                    wr_sel,
    input  logic [ADDR_W-1:0]       wr_data,
    output base_t [N_WIN-1:0]       base_q,
    output map_t  [N_WIN-1:0]       map_q
);
    base_t base_in;
    map_t  map_in;

    assign base_in = '{base_hi: wr_data[ADDR_W-1 -: HI_W], pref: wr_data[3],
                       size: size_e'(wr_data[2:1]), en: wr_data[0]};
    assign map_in  = '{tgt_hi: wr_data[15:8], kind: wr_data[3:1], low_en: wr_data[0]};

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[23:16], wr_data[7:4]};

    for (genvar i = 0; i < N_WIN; i++) begin : g_win
        logic hit_sel;
        assign hit_sel = wr_en && (wr_win == WIN_W'(i));

        always_ff @(posedge clk) begin
            if (rst)
                base_q[i] <= '0;
            else if (hit_sel && !wr_sel)
                base_q[i] <= base_in;
        end

        if (i == IO_IDX) begin : g_io_map
            // I/O window: fixed zero-based mapping, map register not stored.
            assign map_q[i] = '0;
        end else begin : g_mem_map
            always_ff @(posedge clk) begin
                if (rst)
                    map_q[i] <= '0;
                else if (hit_sel && wr_sel)
                    map_q[i] <= map_in;
            end
        end
    end
endmodule

// File: rtl/xlat_window.sv
module xlat_window
    import xlat_pkg::*;
#(
    parameter bit IS_IO = 1'b0
) (
    input  base_t             base,
    input  map_t              map,
    input  logic [ADDR_W-1:0] addr,
    output xlat_t             res
);
    size_e             eff_size;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] tgt_addr;
    logic [ADDR_W-1:0] xa;
    cyc_e              cyc;
    logic              match;

    always_comb begin
        eff_size  = IS_IO ? SZ_16M : base.size;
        mask      = offset_mask(eff_size);
        base_addr = {base.base_hi, {PAGE_LSB{1'b0}}};
        tgt_addr  = {map.tgt_hi, {PAGE_LSB{1'b0}}};
        match     = base.en && (((addr ^ base_addr) & ~mask) == '0);

        if (IS_IO)                    cyc = CYC_IO;
        else if (map.kind == KIND_CFG) cyc = CYC_CFG;
        else                          cyc = CYC_MEM;

        xa = (tgt_addr & ~mask) | (addr & mask);
        if (cyc == CYC_CFG && !map.low_en)
            xa[1:0] = 2'b00;

        res = '0;
        if (match) begin
            res.hit  = 1'b1;
            res.cyc  = cyc;
            res.pref = base.pref && (cyc == CYC_MEM);
            res.addr = xa;
        end
    end
endmodule

// File: rtl/xlat_prio.sv
module xlat_prio
    import xlat_pkg::*;
#(
    parameter int N_WIN = NUM_WIN
) (
    input  xlat_t [N_WIN-1:0] cand,
    output xlat_t             sel,
    output logic [WIN_W-1:0]  sel_idx
);
    // Walk from the top down so the lowest-index hit is written last.
    always_comb begin
        sel     = '0;
        sel_idx = '0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (cand[i].hit) begin
                sel     = cand[i];
                sel_idx = WIN_W'(i);
            end
        end
    end
endmodule

// File: rtl/pci_win_xlat.sv
module pci_win_xlat
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_win,
    input  logic              wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [1:0]        rsp_win,
    output logic [1:0]        rsp_type,
    output logic [31:0]       rsp_addr,
    output logic              rsp_prefetch
);
    base_t [NUM_WIN-1:0] base_q;
    map_t  [NUM_WIN-1:0] map_q;
    xlat_t [NUM_WIN-1:0] cand;
    xlat_t               sel;
    logic [WIN_W-1:0]    sel_idx;
    xlat_t               res_q;
    logic [WIN_W-1:0]    win_q;

    xlat_regs #(.N_WIN(NUM_WIN), .IO_IDX(IO_WIN)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_win  (wr_win),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .base_q  (base_q),
        .map_q   (map_q)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        xlat_window #(.IS_IO(i == IO_WIN)) u_win (
            .base (base_q[i]),
            .map  (map_q[i]),
            .addr (req_addr),
            .res  (cand[i])
        );
    end

    xlat_prio #(.N_WIN(NUM_WIN)) u_prio (
        .cand    (cand),
        .sel     (sel),
        .sel_idx (sel_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            res_q     <= '0;
            win_q     <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                res_q <= sel;
                win_q <= sel_idx;
            end
        end
    end

    assign rsp_hit      = res_q.hit;
    assign rsp_win      = win_q;
    assign rsp_type     = res_q.cyc;
    assign rsp_addr     = res_q.addr;
    assign rsp_prefetch = res_q.pref;
endmodule

// File: rtl/pci_win_xlat_chk.sv
module pci_win_xlat_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [1:0]  rsp_win,
    input logic [1:0]  rsp_type,
    input logic [31:0] rsp_addr,
    input logic        rsp_prefetch
);
    assert_miss_clean_R1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_type == 2'd0 && rsp_addr == 32'd0 &&
                                     rsp_win == 2'd0 && !rsp_prefetch));

    assert_hit_has_type_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit == (rsp_type != 2'd0)));

    assert_cfg_no_pref_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_type == 2'd3) |-> (!rsp_prefetch && rsp_win != 2'd2));

    assert_io_window_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit && rsp_win == 2'd2) |->
            (rsp_type == 2'd2 && !rsp_prefetch && rsp_addr[31:24] == 8'd0));

    assert_io_only_win2_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_type == 2'd2) |-> (rsp_win == 2'd2));

    assert_req_to_rsp_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_idle_no_rsp_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> !rsp_valid);
endmodule

bind pci_win_xlat pci_win_xlat_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_win      (rsp_win),
    .rsp_type     (rsp_type),
    .rsp_addr     (rsp_addr),
    .rsp_prefetch (rsp_prefetch)
);

// File: tb/pci_win_xlat_tb.sv
module pci_win_xlat_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_win = '0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_prefetch;
    logic [1:0]  rsp_win, rsp_type;
    logic [31:0] rsp_addr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pci_win_xlat u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel),
        .wr_data(wr_data), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
        .rsp_type(rsp_type), .rsp_addr(rsp_addr), .rsp_prefetch(rsp_prefetch)
    );

    typedef struct packed {
        logic [31:0] a;
        logic        hit;
        logic [1:0]  win;
        logic [1:0]  cyc;
        logic [31:0] xa;
        logic        pref;
    } vec_t;

    // Memory windows 0/1 at 256 MB, I/O window 2 (size field set to 512 MB, prefetch set).
    localparam vec_t TBL [9] = '{
        '{32'h4000_0000, 1'b1, 2'd0, 2'd1, 32'h0000_0000, 1'b0},
        '{32'h4ABC_DEF4, 1'b1, 2'd0, 2'd1, 32'h0ABC_DEF4, 1'b0},
        '{32'h5000_0000, 1'b1, 2'd1, 2'd1, 32'h1000_0000, 1'b1},
        '{32'h5FFF_FFFF, 1'b1, 2'd1, 2'd1, 32'h1FFF_FFFF, 1'b1},
        '{32'h6000_0000, 1'b1, 2'd2, 2'd2, 32'h0000_0000, 1'b0},
        '{32'h60FF_FFFC, 1'b1, 2'd2, 2'd2, 32'h00FF_FFFC, 1'b0},
        '{32'h6100_0000, 1'b0, 2'd0, 2'd0, 32'h0000_0000, 1'b0},
        '{32'h3FFF_FFFF, 1'b0, 2'd0, 2'd0, 32'h0000_0000, 1'b0},
        '{32'h6800_0000, 1'b0, 2'd0, 2'd0, 32'h0000_0000, 1'b0}
    };

    task automatic wr(input logic [1:0] w, input logic s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_win = w; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic hit, input logic [1:0] win,
                              input logic [1:0] cyc, input logic [31:0] xa, input logic pref);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== hit || rsp_win !== win || rsp_type !== cyc ||
            rsp_addr !== xa || rsp_prefetch !== pref) begin
            errors++;
            $display("FAIL %s: got v=%b hit=%b win=%0d type=%0d addr=%h pref=%b, exp v=1 hit=%b win=%0d type=%0d addr=%h pref=%b",
                     tag, rsp_valid, rsp_hit, rsp_win, rsp_type, rsp_addr, rsp_prefetch,
                     hit, win, cyc, xa, pref);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b exp %b", tag, got, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_bit("R10 rsp_valid in reset", rsp_valid, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R10 rsp_valid after reset", rsp_valid, 1'b0);

        // R1: nothing enabled after reset
        look(32'h4000_0000);
        expect_rsp("R1 miss before programming", 1'b0, 2'd0, 2'd0, 32'h0, 1'b0);

        wr(2'd0, 1'b0, 32'h4000_0003);
        wr(2'd0, 1'b1, 32'h0000_0006);
        wr(2'd1, 1'b0, 32'h5000_000B);
        wr(2'd1, 1'b1, 32'h0000_1006);
        wr(2'd2, 1'b0, 32'h6000_000D);
        wr(2'd2, 1'b1, 32'h0000_AB00);   // R6: ignored

        for (int i = 0; i < 9; i++) begin
            look(TBL[i].a);
            expect_rsp($sformatf("R4/R6/R7 table %0d", i), TBL[i].hit, TBL[i].win,
                       TBL[i].cyc, TBL[i].xa, TBL[i].pref);
        end

        // R8: idle cycle gives no response
        @(negedge clk);
        check_bit("R8 no response when idle", rsp_valid, 1'b0);

        // R2/R3: widen window 0 to 512 MB, hides window 1
        wr(2'd0, 1'b0, 32'h4000_0005);
        look(32'h5000_0010);
        expect_rsp("R2 window0 hides window1", 1'b1, 2'd0, 2'd1, 32'h1000_0010, 1'b0);

        // R5: window 1 to configuration space, 16 MB
        wr(2'd1, 1'b0, 32'h6800_0001);
        wr(2'd1, 1'b1, 32'h0000_000A);
        look(32'h6800_1803);
        expect_rsp("R5 cfg low bits forced", 1'b1, 2'd1, 2'd3, 32'h0000_1800, 1'b0);
        wr(2'd1, 1'b1, 32'h0000_000B);
        look(32'h6800_1803);
        expect_rsp("R5 cfg low bits pass", 1'b1, 2'd1, 2'd3, 32'h0000_1803, 1'b0);
        wr(2'd1, 1'b1, 32'h0000_550A);
        look(32'h6812_3457);
        expect_rsp("R5 cfg target bits", 1'b1, 2'd1, 2'd3, 32'h5512_3454, 1'b0);

        // R3/R2: base 0x6F with 256 MB aligns to 0x60000000, covers window 2
        wr(2'd1, 1'b0, 32'h6F00_0003);
        wr(2'd1, 1'b1, 32'h0000_2006);
        look(32'h6000_0040);
        expect_rsp("R3 alignment, R2 win1 over win2", 1'b1, 2'd1, 2'd1, 32'h2000_0040, 1'b0);

        // R1: disable window 0
        wr(2'd0, 1'b0, 32'h4000_0004);
        look(32'h4000_0000);
        expect_rsp("R1 disabled window misses", 1'b0, 2'd0, 2'd0, 32'h0, 1'b0);

        // R9: write and lookup in the same cycle use the old value
        @(negedge clk);
        wr_en = 1'b1; wr_win = 2'd0; wr_sel = 1'b0; wr_data = 32'h4000_0003;
        req_valid = 1'b1; req_addr = 32'h4000_0010;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        expect_rsp("R9 same-cycle lookup sees old", 1'b0, 2'd0, 2'd0, 32'h0, 1'b0);
        look(32'h4000_0010);
        expect_rsp("R9 next lookup sees new", 1'b1, 2'd0, 2'd1, 32'h0000_0010, 1'b0);

        // R8: back-to-back lookups
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h6000_1234;
        @(negedge clk);
        req_addr = 32'h4000_0020;
        expect_rsp("R8 back-to-back first", 1'b1, 2'd1, 2'd1, 32'h2000_1234, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp("R8 back-to-back second", 1'b1, 2'd0, 2'd1, 32'h0000_0020, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule